// File: doc/BRIEF.md
# Dual-Channel Compare Output Unit with Force Strobe

This block drives two waveform pins from a 16-bit timer. Each channel compares the running count against its own threshold. On a hit while the timer is counting, the channel applies a 2-bit pin action and raises its match flag. Channel A can also serve as the period limit. In that case a hit on A raises a one-cycle request to restart the counter.

Each channel has a force strobe, which software writes to inject a compare event without waiting for the counter. A forced event moves the pin exactly as a real hit would. It never raises the flag and never requests a counter restart. Force strobes only act while the timer runs a non-PWM waveform. In PWM modes, pin shaping is left to other logic: this unit holds its pins, and forces are ignored.

The pins, flags and restart request are all registered. They change one clock after the hit or the strobe that caused them.

Top module: `dual_compare_out`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pin_a`, `pin_b`, `flag_a`, `flag_b` and `cnt_clr` are all 0.
- R2: When `cnt_en` is 1 and `cnt` equals a channel's threshold at a clock edge, that channel's flag reads 1 after that edge. Equality while `cnt_en` is 0 causes no hit.
- R3: In non-PWM mode (`pwm_mode`=0), a channel event applies the channel's 2-bit action to its pin on the next edge: 00 holds the pin, 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R4: A force strobe in non-PWM mode produces the same pin change as a hit and leaves the channel's flag unchanged.
- R5: A hit on channel A while `top_a` is 1 makes `cnt_clr` 1 for the following cycle. A force on A never does, even when `top_a` is 1.
- R6: While `pwm_mode` is 1, force strobes have no effect and both pins hold their value.
- R7: Writing 1 to a flag-clear input clears that flag on the next edge. A hit in the same cycle wins, and the flag stays 1.
- R8: A hit and a force in the same cycle on one channel apply the pin action once. For example, a toggle flips the pin once and does not flip it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | 16 | Current timer count |
| cnt_en | input | 1 | Timer counts in this cycle |
| cmp_a | input | 16 | Channel A threshold |
| cmp_b | input | 16 | Channel B threshold |
| mode_a | input | 2 | Channel A pin action |
| mode_b | input | 2 | Channel B pin action |
| pwm_mode | input | 1 | 1 = PWM waveform active |
| top_a | input | 1 | Channel A sets the counter period |
| force_a | input | 1 | Force strobe, channel A |
| force_b | input | 1 | Force strobe, channel B |
| flag_clr_a | input | 1 | Write-one-to-clear for flag A |
| flag_clr_b | input | 1 | Write-one-to-clear for flag B |
| pin_a | output | 1 | Channel A waveform pin |
| pin_b | output | 1 | Channel B waveform pin |
| flag_a | output | 1 | Channel A match flag |
| flag_b | output | 1 | Channel B match flag |
| cnt_clr | output | 1 | One-cycle counter restart request |

## Verification
On every cycle the assertions check the following:
- a hit always raises its flag, and a hit beats a same-cycle clear;
- a force alone never raises a flag or a restart request;
- pins hold while PWM is active;
- a toggle event always changes the pin.

Some behaviour only the bench's scenarios can show:
- the full action encoding per channel;
- that gating by `cnt_en` suppresses hits;
- the one-cycle timing of the restart pulse;
- that a combined hit and force toggles the pin only once.

These are compared against a behavioural model on every clock.

// File: rtl/dual_compare_out.sv
module dual_compare_out #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_en,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic [1:0]    mode_a,
  input  logic [1:0]    mode_b,
  input  logic          pwm_mode,
  input  logic          top_a,
  input  logic          force_a,
  input  logic          force_b,
  input  logic          flag_clr_a,
  input  logic          flag_clr_b,
  output logic          pin_a,
  output logic          pin_b,
  output logic          flag_a,
  output logic          flag_b,
  output logic          cnt_clr
);

  localparam logic [1:0] ACT_HOLD = 2'b00;
  localparam logic [1:0] ACT_TOG  = 2'b01;
  localparam logic [1:0] ACT_LOW  = 2'b10;

  wire hit_a  = cnt_en && (cnt == cmp_a);
  wire hit_b  = cnt_en && (cnt == cmp_b);
  wire fire_a = !pwm_mode && (hit_a || force_a);
  wire fire_b = !pwm_mode && (hit_b || force_b);

  function automatic logic apply_act(input logic cur, input logic [1:0] act);
    case (act)
      ACT_HOLD: apply_act = cur;
      ACT_TOG:  apply_act = ~cur;
      ACT_LOW:  apply_act = 1'b0;
      default:  apply_act = 1'b1;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_a   <= 1'b0;
      pin_b   <= 1'b0;
      flag_a  <= 1'b0;
      flag_b  <= 1'b0;
      cnt_clr <= 1'b0;
    end else begin
      if (fire_a) pin_a <= apply_act(pin_a, mode_a);
      if (fire_b) pin_b <= apply_act(pin_b, mode_b);
      flag_a  <= hit_a | (flag_a & ~flag_clr_a);
      flag_b  <= hit_b | (flag_b & ~flag_clr_b);
      cnt_clr <= hit_a & top_a;
    end
  end

  AST_HIT_SETS_FLAG_A: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt == cmp_a) |=> flag_a);  // R2
  AST_SET_BEATS_CLEAR_B: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt == cmp_b && flag_clr_b) |=> flag_b);  // R7
  AST_FORCE_NO_FLAG_A: assert property (@(posedge clk) disable iff (!rst_n)
    (force_a && !(cnt_en && cnt == cmp_a) && !flag_a) |=> !flag_a);  // R4
  AST_FORCE_NO_FLAG_B: assert property (@(posedge clk) disable iff (!rst_n)
    (force_b && !(cnt_en && cnt == cmp_b) && !flag_b) |=> !flag_b);  // R4
  AST_NO_RESTART_WITHOUT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en && cnt == cmp_a) |=> !cnt_clr);  // R5
  AST_PWM_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode |=> ($stable(pin_a) && $stable(pin_b)));  // R6
  AST_TOGGLE_FLIPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && mode_a == 2'b01 && (force_a || (cnt_en && cnt == cmp_a)))
      |=> (pin_a != $past(pin_a)));  // R3

endmodule

// File: tb/test_dual_compare_out.sv
module test_dual_compare_out;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cnt = '0, cmp_a = 16'd5, cmp_b = 16'd9;
  logic cnt_en = 1'b0, pwm_mode = 1'b0, top_a = 1'b0;
  logic [1:0] mode_a = 2'b00, mode_b = 2'b00;
  logic force_a = 1'b0, force_b = 1'b0, flag_clr_a = 1'b0, flag_clr_b = 1'b0;
  logic pin_a, pin_b, flag_a, flag_b, cnt_clr;

  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R1";
  logic e_pa = 0, e_pb = 0, e_fa = 0, e_fb = 0, e_clr = 0;

  dual_compare_out i_dual_compare_out (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("pin_a", pin_a, e_pa);
    chk("pin_b", pin_b, e_pb);
    chk("flag_a", flag_a, e_fa);
    chk("flag_b", flag_b, e_fb);
    chk("cnt_clr", cnt_clr, e_clr);
  endtask

  function automatic logic act_on(input logic p, input logic [1:0] m);
    if (m == 2'd1) return ~p;
    if (m == 2'd2) return 1'b0;
    if (m == 2'd3) return 1'b1;
    return p;
  endfunction

  task automatic step();
    bit ha, hb;
    @(posedge clk);
    ha = cnt_en && (cnt == cmp_a);
    hb = cnt_en && (cnt == cmp_b);
    if (!pwm_mode && (ha || force_a)) e_pa = act_on(e_pa, mode_a);
    if (!pwm_mode && (hb || force_b)) e_pb = act_on(e_pb, mode_b);
    e_fa = ha ? 1'b1 : (flag_clr_a ? 1'b0 : e_fa);
    e_fb = hb ? 1'b1 : (flag_clr_b ? 1'b0 : e_fb);
    e_clr = ha && top_a;
    @(negedge clk);
    check_all();
    force_a = 0; force_b = 0; flag_clr_a = 0; flag_clr_b = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    #(CLK_PERIOD*2 + 1);
    check_all();
    @(negedge clk); rst_n = 1'b1;
    step();

    tag = "R2 gated";            // equality without counting
    cnt = 16'd5; cnt_en = 0; step();
    tag = "R2 ramp";
    cnt_en = 1;
    for (int i = 0; i < 12; i++) begin cnt = 16'(i); step(); end

    tag = "R7 w1c";
    cnt = 16'd100; flag_clr_a = 1; flag_clr_b = 1; step();
    tag = "R7 set wins";
    cnt = 16'd9; flag_clr_b = 1; step();

    tag = "R3 modes";
    for (int m = 0; m < 4; m++) begin
      mode_a = 2'(m); mode_b = 2'(3 - m);
      cnt = 16'd5; step();
      cnt = 16'd9; step();
      cnt = 16'd5; step();
    end

    tag = "R4 force";
    cnt_en = 0; flag_clr_a = 1; flag_clr_b = 1; step();
    mode_a = 2'd1; mode_b = 2'd1;
    for (int i = 0; i < 3; i++) begin force_a = 1; force_b = 1; step(); end
    mode_a = 2'd2; mode_b = 2'd3; force_a = 1; force_b = 1; step();
    step();

    tag = "R5 force no restart";
    top_a = 1; mode_a = 2'd1; force_a = 1; step(); step();
    tag = "R5 hit restart";
    cnt_en = 1; cnt = 16'd5; step();
    cnt = 16'd0; step();

    tag = "R8 hit+force";
    mode_a = 2'd1; mode_b = 2'd1;
    cnt = 16'd5; force_a = 1; step();
    cnt = 16'd9; force_b = 1; step();

    tag = "R6 pwm";
    pwm_mode = 1; cnt_en = 0;
    mode_a = 2'd1; mode_b = 2'd1;
    force_a = 1; force_b = 1; step();
    force_a = 1; force_b = 1; step();
    cnt_en = 1; cnt = 16'd5; step();
    pwm_mode = 0; cnt_en = 0; force_a = 1; step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule